// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block takes configuration words from a three-line serial link (clock, data, enable) and delivers the programmed values to a frequency synthesizer core. The values are a reference divide ratio, a main divide ratio, a swallow count and a set of mode bits. All three serial lines are sampled in the system clock domain. Each complete word ends with a two-bit destination code, and the loader uses that code to steer the word to the reference-divider register, the main/swallow register or one of two status registers. Words of the wrong length, and divider values outside their legal range, are dropped.

Divider values pass through a shadow stage. In immediate mode a new ratio goes straight to the active outputs. In aligned mode both shadows wait until the reference divider and the main divider signal the end of a cycle in the same clock. This keeps the phase relation between the two divided clocks. A status word picks immediate or aligned transfer, so it should be written before any divider word. Status words always take effect at once. They also carry a two-bit power-down code, decoded into a full power-down and a core-only power-down.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset the active reference ratio is 10, the main ratio is 10, the swallow count is 0, and all mode and power-down outputs are 0.
- R2: While `ser_en` is high, a bit is taken from `ser_data` on each rising edge of `ser_clk`, most significant bit first. The falling edge of `ser_en` closes the word. A word is 23 bits, and the last two bits received (bits 1:0) are the destination code.
- R3: Destination code 0 writes the reference ratio from word bits 17:2. Code 1 writes the main ratio from bits 22:9 and the swallow count from bits 8:2. Code 2 is status A: bits 3:2 are the power-down code and bit 4 inverts the detector polarity. Code 3 is status B: bit 2 selects dual-modulus operation and bit 3 selects aligned transfer.
- R4: A word with more or fewer than 23 clocked bits leaves every output unchanged.
- R5: In immediate mode (status B bit 3 = 0), an accepted divider word reaches the active outputs within ten system clocks of the falling edge of `ser_en`.
- R6: In aligned mode, divider words only update the shadows. On the first clock after the word has been accepted in which `r_tick` and `n_tick` are both high, both shadows are copied to the active outputs. A tick from only one divider copies nothing.
- R7: A reference ratio below 3 is discarded. A main/swallow word whose main ratio is outside 3 to 16380 is discarded.
- R8: Power-down code 01 asserts `stby_full`, code 10 asserts `stby_core`, and codes 00 and 11 assert neither. The two outputs are never high together.
- R9: Status words take effect immediately, in either transfer mode.
- R10: When several divider words arrive in aligned mode before a coincident tick, the transfer uses the most recent accepted value of each register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data |
| ser_en | input | 1 | Serial frame enable |
| r_tick | input | 1 | Reference divider end-of-cycle strobe |
| n_tick | input | 1 | Main divider end-of-cycle strobe |
| r_div | output | 16 | Active reference ratio |
| n_div | output | 14 | Active main ratio |
| a_div | output | 7 | Active swallow count |
| dual_mode | output | 1 | Dual-modulus operation selected |
| sync_mode | output | 1 | Aligned transfer selected |
| pd_invert | output | 1 | Detector polarity inverted |
| stby_full | output | 1 | Full power-down |
| stby_core | output | 1 | Core-only power-down |

## Verification
The hardest case to reach from the ports is an aligned transfer that has words pending in both shadows, including a shadow that was overwritten, while single-divider ticks go past and must not trigger a copy. The stimulus first switches to aligned mode with a status word. It then loads two reference words and one main/swallow word, and checks that the outputs hold through a lone `r_tick` and a lone `n_tick`. Finally it raises both ticks together and expects the latest shadow values. Short words, long words and out-of-range ratios are sent between valid words, and the outputs are checked to stay unchanged.

// File: rtl/cfg_pkg.sv
// Shared constants and types for the serial configuration loader.
// Assumes a two-bit destination code at the tail of every word.
package cfg_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        DST_REF  = 2'd0,
        DST_MAIN = 2'd1,
        DST_STA  = 2'd2,
        DST_STB  = 2'd3
    } dest_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'b00,
        PWR_FULL = 2'b01,
        PWR_CORE = 2'b10,
        PWR_ALT  = 2'b11
    } pwr_e;
endpackage

// File: rtl/ser_word_rx.sv
// Serial word receiver: synchronizes the three serial lines into clk,
// shifts data MSB first on serial clock rises while enable is high, and
// emits a one-cycle valid when enable falls after exactly WORD_W bits.
// Assumes each serial level is held for at least three system clocks.
module ser_word_rx #(
    parameter int WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_en,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_SAT = WORD_W + 1;
    localparam int NSYNC   = 3;

    logic [NSYNC-1:0] raw, st1, st2;
    logic             clk_q, en_q;
    logic [CNT_W-1:0] cnt;

    assign raw = {ser_en, ser_data, ser_clk};

    // Two-stage synchronizer for each serial line.
    generate
        for (genvar g = 0; g < NSYNC; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st1[g] <= 1'b0;
                    st2[g] <= 1'b0;
                end else begin
                    st1[g] <= raw[g];
                    st2[g] <= st1[g];
                end
            end
        end
    endgenerate

    wire clk_rise = st2[0] & ~clk_q;
    wire en_rise  = st2[2] & ~en_q;
    wire en_fall  = en_q & ~st2[2];

    // Delayed copies of the synchronized clock and enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            clk_q <= st2[0];
            en_q  <= st2[2];
        end
    end

    // Shift register and saturating bit counter for the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (en_rise) begin
            cnt <= '0;
        end else if (st2[2] && clk_rise) begin
            word <= {word[WORD_W-2:0], st2[1]};
            if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
        end
    end

    // Frame-complete pulse, only for a frame of the exact length.
    always_ff @(posedge clk) begin
        if (!rst_n) word_valid <= 1'b0;
        else        word_valid <= en_fall && (cnt == CNT_W'(WORD_W));
    end
endmodule

// File: rtl/cfg_decode.sv
// Destination decoder: splits a received word by its destination code,
// range-checks divider values, and holds the two status registers.
// Assumes word is stable while word_valid is high.
module cfg_decode
    import cfg_pkg::*;
#(
    parameter int R_W   = 16,
    parameter int N_W   = 14,
    parameter int A_W   = 7,
    parameter int R_MIN = 3,
    parameter int N_MIN = 3,
    parameter int N_MAX = 16380
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_valid,
    input  logic [N_W+A_W+1:0]    word,
    output logic                  r_load,
    output logic [R_W-1:0]        r_val,
    output logic                  na_load,
    output logic [N_W-1:0]        n_val,
    output logic [A_W-1:0]        a_val,
    output logic                  dual_mode,
    output logic                  sync_mode,
    output logic                  pd_invert,
    output logic                  stby_full,
    output logic                  stby_core
);
    localparam int WORD_W = N_W + A_W + ADDR_W;

    dest_e dest;
    pwr_e  pwr_code;
    logic  r_ok, n_ok;

    // Field extraction and range checks on the latched word.
    always_comb begin
        dest  = dest_e'(word[ADDR_W-1:0]);
        r_val = word[R_W+ADDR_W-1:ADDR_W];
        n_val = word[WORD_W-1 -: N_W];
        a_val = word[A_W+ADDR_W-1:ADDR_W];
        r_ok  = (int'(r_val) >= R_MIN);
        n_ok  = (int'(n_val) >= N_MIN) && (int'(n_val) <= N_MAX);
        r_load  = word_valid && (dest == DST_REF)  && r_ok;
        na_load = word_valid && (dest == DST_MAIN) && n_ok;
    end

    // Status A register: power-down code and detector polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_code  <= PWR_RUN;
            pd_invert <= 1'b0;
        end else if (word_valid && dest == DST_STA) begin
            pwr_code  <= pwr_e'(word[ADDR_W+1:ADDR_W]);
            pd_invert <= word[ADDR_W+2];
        end
    end

    // Status B register: modulus mode and transfer mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dual_mode <= 1'b0;
            sync_mode <= 1'b0;
        end else if (word_valid && dest == DST_STB) begin
            dual_mode <= word[ADDR_W];
            sync_mode <= word[ADDR_W+1];
        end
    end

    // Power-down code decode.
    always_comb begin
        stby_full = (pwr_code == PWR_FULL);
        stby_core = (pwr_code == PWR_CORE);
    end

    assert_stby_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stby_full, stby_core}));
endmodule

// File: rtl/cfg_commit.sv
// Shadow and active divider registers. In immediate mode accepted values
// go straight to the active outputs; in aligned mode they wait in the
// shadows until both divider strobes coincide, then move together.
// Assumes r_tick and n_tick are single-cycle strobes in the clk domain.
module cfg_commit #(
    parameter int R_W   = 16,
    parameter int N_W   = 14,
    parameter int A_W   = 7,
    parameter int R_MIN = 3,
    parameter int N_MIN = 3,
    parameter int N_MAX = 16380,
    parameter int R_RST = 10,
    parameter int N_RST = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           r_load,
    input  logic [R_W-1:0] r_val,
    input  logic           na_load,
    input  logic [N_W-1:0] n_val,
    input  logic [A_W-1:0] a_val,
    input  logic           sync_mode,
    input  logic           r_tick,
    input  logic           n_tick,
    output logic [R_W-1:0] r_div,
    output logic [N_W-1:0] n_div,
    output logic [A_W-1:0] a_div
);
    logic [R_W-1:0] r_sh;
    logic [N_W-1:0] n_sh;
    logic [A_W-1:0] a_sh;
    logic           pending;

    wire coincide = r_tick & n_tick;
    wire commit   = pending & coincide;

    // Shadow registers always track the latest accepted value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_sh <= R_W'(R_RST);
            n_sh <= N_W'(N_RST);
            a_sh <= '0;
        end else begin
            if (r_load)  r_sh <= r_val;
            if (na_load) begin
                n_sh <= n_val;
                a_sh <= a_val;
            end
        end
    end

    // Pending flag: set by an aligned-mode load, cleared by a coincident tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                               pending <= 1'b0;
        else if ((r_load || na_load) && sync_mode) pending <= 1'b1;
        else if (commit)                          pending <= 1'b0;
    end

    // Active reference ratio: immediate load or aligned commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                     r_div <= R_W'(R_RST);
        else if (r_load && !sync_mode)  r_div <= r_val;
        else if (commit)                r_div <= r_sh;
    end

    // Active main ratio and swallow count: immediate load or aligned commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_div <= N_W'(N_RST);
            a_div <= '0;
        end else if (na_load && !sync_mode) begin
            n_div <= n_val;
            a_div <= a_val;
        end else if (commit) begin
            n_div <= n_sh;
            a_div <= a_sh;
        end
    end

    assert_r_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(r_div) >= R_MIN);
    assert_n_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(n_div) >= N_MIN) && (int'(n_div) <= N_MAX));
    assert_hold_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !coincide) |=> $stable(r_div));
    assert_hold_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !coincide) |=> ($stable(n_div) && $stable(a_div)));
    assert_pending_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && coincide && !r_load && !na_load) |=> !pending);
endmodule

// File: rtl/synth_cfg_loader.sv
// Top level of the serial configuration loader: receiver, destination
// decoder and shadow/active commit stage in series.
// Assumes all inputs other than the serial lines are in the clk domain.
module synth_cfg_loader #(
    parameter int R_W   = 16,
    parameter int N_W   = 14,
    parameter int A_W   = 7,
    parameter int R_MIN = 3,
    parameter int N_MIN = 3,
    parameter int N_MAX = 16380,
    parameter int R_RST = 10,
    parameter int N_RST = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_en,
    input  logic           r_tick,
    input  logic           n_tick,
    output logic [R_W-1:0] r_div,
    output logic [N_W-1:0] n_div,
    output logic [A_W-1:0] a_div,
    output logic           dual_mode,
    output logic           sync_mode,
    output logic           pd_invert,
    output logic           stby_full,
    output logic           stby_core
);
    localparam int WORD_W = N_W + A_W + cfg_pkg::ADDR_W;

    logic              word_valid;
    logic [WORD_W-1:0] word;
    logic              r_load, na_load;
    logic [R_W-1:0]    r_val;
    logic [N_W-1:0]    n_val;
    logic [A_W-1:0]    a_val;

    ser_word_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
        .word_valid(word_valid), .word(word)
    );

    cfg_decode #(
        .R_W(R_W), .N_W(N_W), .A_W(A_W),
        .R_MIN(R_MIN), .N_MIN(N_MIN), .N_MAX(N_MAX)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word(word),
        .r_load(r_load), .r_val(r_val),
        .na_load(na_load), .n_val(n_val), .a_val(a_val),
        .dual_mode(dual_mode), .sync_mode(sync_mode), .pd_invert(pd_invert),
        .stby_full(stby_full), .stby_core(stby_core)
    );

    cfg_commit #(
        .R_W(R_W), .N_W(N_W), .A_W(A_W),
        .R_MIN(R_MIN), .N_MIN(N_MIN), .N_MAX(N_MAX),
        .R_RST(R_RST), .N_RST(N_RST)
    ) u_commit (
        .clk(clk), .rst_n(rst_n),
        .r_load(r_load), .r_val(r_val),
        .na_load(na_load), .n_val(n_val), .a_val(a_val),
        .sync_mode(sync_mode), .r_tick(r_tick), .n_tick(n_tick),
        .r_div(r_div), .n_div(n_div), .a_div(a_div)
    );
endmodule

// File: tb/test_synth_cfg_loader.sv
// Scoreboard bench: driver tasks push expected output states into a queue,
// a monitor pops each one after the next clock edge and compares.
module test_synth_cfg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
    logic r_tick = 1'b0, n_tick = 1'b0;
    logic [15:0] r_div;
    logic [13:0] n_div;
    logic [6:0]  a_div;
    logic dual_mode, sync_mode, pd_invert, stby_full, stby_core;

    always #4 clk = ~clk;

    synth_cfg_loader i_synth_cfg_loader (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
        .r_tick(r_tick), .n_tick(n_tick),
        .r_div(r_div), .n_div(n_div), .a_div(a_div),
        .dual_mode(dual_mode), .sync_mode(sync_mode), .pd_invert(pd_invert),
        .stby_full(stby_full), .stby_core(stby_core)
    );

    typedef struct {
        logic [15:0] r;
        logic [13:0] n;
        logic [6:0]  a;
        logic [4:0]  flags; // dual, sync, pol, full, core
        string       tag;
    } exp_t;

    exp_t q[$];
    int vectors = 0;
    int miscomp = 0;
    bit done = 0;

    // Bench model of the expected outputs.
    logic [15:0] m_r = 16'd10;
    logic [13:0] m_n = 14'd10;
    logic [6:0]  m_a = 7'd0;
    logic m_dual = 0, m_sync = 0, m_pol = 0, m_full = 0, m_core = 0;

    task automatic expect_state(input string tag);
        exp_t e;
        e.r = m_r; e.n = m_n; e.a = m_a;
        e.flags = {m_dual, m_sync, m_pol, m_full, m_core};
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare every queued expectation just after a clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                logic [4:0] got;
                bit bad;
                e = q.pop_front();
                got = {dual_mode, sync_mode, pd_invert, stby_full, stby_core};
                bad = 0;
                vectors++;
                if (r_div !== e.r) begin
                    $display("FAIL %s r_div actual %0d expected %0d", e.tag, r_div, e.r); bad = 1;
                end
                if (n_div !== e.n) begin
                    $display("FAIL %s n_div actual %0d expected %0d", e.tag, n_div, e.n); bad = 1;
                end
                if (a_div !== e.a) begin
                    $display("FAIL %s a_div actual %0d expected %0d", e.tag, a_div, e.a); bad = 1;
                end
                if (got !== e.flags) begin
                    $display("FAIL %s flags actual %b expected %b", e.tag, got, e.flags); bad = 1;
                end
                if (bad) miscomp++;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nbits of w, MSB first, framed by the enable line.
    task automatic send_bits(input logic [31:0] w, input int nbits);
        ser_en = 1'b1;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_data = w[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(2);
        ser_en = 1'b0;
        wait_clk(10);
    endtask

    function automatic logic [22:0] w_ref(input logic [15:0] r);
        return {5'd0, r, 2'd0};
    endfunction
    function automatic logic [22:0] w_main(input logic [13:0] n, input logic [6:0] a);
        return {n, a, 2'd1};
    endfunction
    function automatic logic [22:0] w_sta(input logic [1:0] code, input logic pol);
        return {18'd0, pol, code, 2'd2};
    endfunction
    function automatic logic [22:0] w_stb(input logic dual, input logic sync);
        return {19'd0, sync, dual, 2'd3};
    endfunction

    task automatic tick(input logic rt, input logic nt);
        @(negedge clk);
        r_tick = rt; n_tick = nt;
        @(negedge clk);
        r_tick = 1'b0; n_tick = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(1);
        expect_state("R1 reset state");

        // Immediate-mode divider loads.
        send_bits(32'(w_ref(16'd1234)), 23); m_r = 16'd1234;
        expect_state("R2 R3 R5 ref word");
        send_bits(32'(w_main(14'd500, 7'd37)), 23); m_n = 14'd500; m_a = 7'd37;
        expect_state("R3 R5 main word");

        // Status A codes.
        send_bits(32'(w_sta(2'b01, 1'b1)), 23); m_full = 1; m_pol = 1;
        expect_state("R8 code 01 full");
        send_bits(32'(w_sta(2'b10, 1'b0)), 23); m_full = 0; m_core = 1; m_pol = 0;
        expect_state("R8 code 10 core");
        send_bits(32'(w_sta(2'b11, 1'b0)), 23); m_core = 0;
        expect_state("R8 code 11 run");

        // Length errors.
        send_bits(32'(w_ref(16'd999)) >> 1, 22);
        expect_state("R4 short word");
        send_bits({9'd0, 1'b1, w_ref(16'd999)}, 24);
        expect_state("R4 long word");

        // Range checks and boundaries.
        send_bits(32'(w_ref(16'd2)), 23);
        expect_state("R7 ref 2 dropped");
        send_bits(32'(w_main(14'd16381, 7'd1)), 23);
        expect_state("R7 main 16381 dropped");
        send_bits(32'(w_main(14'd2, 7'd1)), 23);
        expect_state("R7 main 2 dropped");
        send_bits(32'(w_ref(16'd3)), 23); m_r = 16'd3;
        expect_state("R7 ref 3 accepted");
        send_bits(32'(w_main(14'd16380, 7'd127)), 23); m_n = 14'd16380; m_a = 7'd127;
        expect_state("R7 main 16380 accepted");

        // Aligned mode.
        send_bits(32'(w_stb(1'b1, 1'b1)), 23); m_dual = 1; m_sync = 1;
        expect_state("R3 R9 status B");
        tick(1'b1, 1'b1);
        expect_state("R6 tick with nothing pending");
        send_bits(32'(w_ref(16'd800)), 23);
        send_bits(32'(w_main(14'd300, 7'd5)), 23);
        send_bits(32'(w_ref(16'd900)), 23);
        expect_state("R6 held in shadow");
        tick(1'b1, 1'b0);
        expect_state("R6 lone ref tick");
        tick(1'b0, 1'b1);
        expect_state("R6 lone main tick");
        send_bits(32'(w_sta(2'b10, 1'b1)), 23); m_core = 1; m_pol = 1;
        expect_state("R9 status in aligned mode");
        tick(1'b1, 1'b1); m_r = 16'd900; m_n = 14'd300; m_a = 7'd5;
        expect_state("R6 R10 coincident commit");

        // Back to immediate mode.
        send_bits(32'(w_stb(1'b0, 1'b0)), 23); m_dual = 0; m_sync = 0;
        send_bits(32'(w_ref(16'd65535)), 23); m_r = 16'd65535;
        expect_state("R5 immediate after aligned");

        wait_clk(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule